// File: doc/BRIEF.md
# Windowed Frame Buffer

This block holds whole packets as runs of 32-bit words in a circular word store. A writer appends words to the frame it is building. It then either commits that frame, which makes it visible to the reader, or aborts it, which throws away everything written since the last commit or abort. Committed frames stay in the buffer until the reader releases them one at a time, oldest first.

The reader does not consume frames directly. It looks at one frame through a window that can be reset to the oldest unreleased frame and stepped forward frame by frame, so frames that were already read can be sent again until they are released. Within the window frame, a word index advances with each read strobe, and a restart strobe rewinds it to the first word. A parameter chooses how the end of a frame is signalled: either the end marker comes with the last data word, or it comes on one extra read that carries no data. Three flags report whether any unreleased frame exists, whether the window sits on a frame, and whether that frame still has unread words.

Top module: `win_frame_buf`

## Requirements
- R1: A word-read strobe, accepted when the window holds a frame with unread words and no window-control strobe (release, window reset, window next, restart) is present in the same cycle, places the next 32-bit word of the window frame on `rd_data_o` in the cycle after the strobe and advances the word index by one.
- R2: With `END_MODE` set to END_WITH_LAST, `rd_last_o` is 1 with the last word of a frame and 0 with every other word. A word-read strobe after the last word is ignored, and `rd_data_o` and `rd_last_o` hold their values.
- R3: With `END_MODE` set to END_AFTER_LAST, `rd_last_o` is 0 with every data word. A word-read strobe issued once all words have been read sets `rd_last_o` to 1, and `rd_data_o` carries no meaning on that read.
- R4: A commit strobe closes the frame being written, records its length and makes it visible to the reader. A commit made when the frame holds no words creates no frame. A word strobed in the same cycle as a commit belongs to the committed frame.
- R5: An abort strobe discards the words of the frame under construction, so that frame never becomes visible to the reader.
- R6: A release strobe frees the oldest unreleased frame. When no frame is stored, a release changes nothing. If the window sits on the released frame, the window moves to the next frame and the word index is cleared.
- R7: A window-reset strobe places the window on the oldest unreleased frame and clears the word index.
- R8: A window-next strobe moves the window to the following committed frame and clears the word index. It is ignored when the window already sits past the newest committed frame.
- R9: A restart strobe clears the word index, so the window frame is read again from its first word.
- R10: `frame_empty_o` is 1 when no committed frame is unreleased. `win_empty_o` is 1 when the window sits past the newest committed frame. `word_empty_o` is 1 when the window is empty or every word of the window frame has been read. After reset all three flags are 1 and `rd_last_o` is 0.
- R11: At most 2^`FRAME_AW` frames can be unreleased at once. A commit made while that many frames are stored is dropped.
- R12: A word that does not fit in the free part of the 2^`WORD_AW`-word store puts the writer into a drop state. The next commit then discards the frame, and that commit, or an abort, clears the drop state. Space freed by releases is reused circularly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_word_i | input | 1 | Append `wr_data_i` to the frame under construction |
| wr_data_i | input | 32 | Word to append |
| wr_commit_i | input | 1 | Close and publish the frame under construction |
| wr_abort_i | input | 1 | Discard the frame under construction |
| rd_release_i | input | 1 | Free the oldest unreleased frame |
| rd_win_reset_i | input | 1 | Move the window to the oldest unreleased frame |
| rd_win_next_i | input | 1 | Step the window to the next frame |
| rd_restart_i | input | 1 | Rewind the word index of the window frame |
| rd_word_i | input | 1 | Read the next word of the window frame |
| rd_data_o | output | 32 | Word returned by the previous read |
| rd_last_o | output | 1 | End-of-frame marker, timing set by `END_MODE` |
| frame_empty_o | output | 1 | No unreleased frame |
| win_empty_o | output | 1 | Window holds no frame |
| word_empty_o | output | 1 | No unread word in the window frame |

## Verification
The bench sweeps frame lengths through a small store of four frames and sixteen words, so the word address wraps several times. A design that masked the address wrongly would return words from stale frames. Two instances, one per end-marker mode, receive the same stimulus, which shows whether the marker comes with the last word or one read later. A single off-by-one error in the index compare would move the marker in both. Replay runs step the window past the newest frame, try one step too many, reset it, and release the frame under the window. A design that moved the window past the newest frame, or left it on a freed frame, would read the wrong tags. Zero-word commits, aborted frames, a fifth commit into a full frame table and a seventeen-word frame target the refusal paths. A design that accepted any of them would show a frame where `frame_empty_o` must stay high.

// File: rtl/wfb_pkg.sv
package wfb_pkg;
    typedef enum logic {
        END_AFTER_LAST = 1'b0,
        END_WITH_LAST  = 1'b1
    } end_mode_e;

    localparam int unsigned WORD_W = 32;
endpackage

// File: rtl/wfb_word_ram.sv
module wfb_word_ram #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rdata_o <= '0;
        else if (re_i) rdata_o <= mem_q[raddr_i];
    end
endmodule

// File: rtl/wfb_desc_table.sv
module wfb_desc_table #(
    parameter int unsigned FRAME_AW = 6,
    parameter int unsigned WORD_AW  = 8,
    localparam int unsigned LEN_W  = WORD_AW + 1,
    localparam int unsigned FRAMES = 1 << FRAME_AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [FRAME_AW-1:0] waddr_i,
    input  logic [WORD_AW-1:0]  wstart_i,
    input  logic [LEN_W-1:0]    wlen_i,
    input  logic [FRAME_AW-1:0] rel_addr_i,
    output logic [LEN_W-1:0]    rel_len_o,
    input  logic [FRAME_AW-1:0] win_addr_i,
    output logic [WORD_AW-1:0]  win_start_o,
    output logic [LEN_W-1:0]    win_len_o
);
    logic [WORD_AW-1:0] start_q [FRAMES];
    logic [LEN_W-1:0]   len_q   [FRAMES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < FRAMES; k++) begin
                start_q[k] <= '0;
                len_q[k]   <= '0;
            end
        end else if (we_i) begin
            start_q[waddr_i] <= wstart_i;
            len_q[waddr_i]   <= wlen_i;
        end
    end

    assign rel_len_o   = len_q[rel_addr_i];
    assign win_start_o = start_q[win_addr_i];
    assign win_len_o   = len_q[win_addr_i];
endmodule

// File: rtl/wfb_writer.sv
module wfb_writer #(
    parameter int unsigned FRAME_AW = 6,
    parameter int unsigned WORD_AW  = 8,
    localparam int unsigned FP_W   = FRAME_AW + 1,
    localparam int unsigned LEN_W  = WORD_AW + 1,
    localparam int unsigned FRAMES = 1 << FRAME_AW,
    localparam int unsigned DEPTH  = 1 << WORD_AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_word_i,
    input  logic                wr_commit_i,
    input  logic                wr_abort_i,
    input  logic [FP_W-1:0]     tail_ptr_i,
    input  logic                rel_fire_i,
    input  logic [LEN_W-1:0]    rel_len_i,
    output logic [FP_W-1:0]     head_ptr_o,
    output logic                mem_we_o,
    output logic [WORD_AW-1:0]  mem_waddr_o,
    output logic                desc_we_o,
    output logic [FRAME_AW-1:0] desc_waddr_o,
    output logic [WORD_AW-1:0]  desc_start_o,
    output logic [LEN_W-1:0]    desc_len_o
);
    typedef struct packed {
        logic [FP_W-1:0]    head;
        logic [WORD_AW-1:0] wa;
        logic [WORD_AW-1:0] fs;
        logic [LEN_W-1:0]   wcnt;
        logic [LEN_W-1:0]   used;
        logic               drop;
    } wr_state_t;

    wr_state_t s_d, s_q;
    logic      room, table_full;
    logic [LEN_W-1:0] len_d;

    assign room       = ({1'b0, s_q.used} + {1'b0, s_q.wcnt}) < (LEN_W+1)'(DEPTH);
    assign table_full = (s_q.head - tail_ptr_i) == FP_W'(FRAMES);

    always_comb begin
        s_d       = s_q;
        mem_we_o  = 1'b0;
        desc_we_o = 1'b0;
        if (wr_word_i) begin
            if (!s_q.drop && room) begin
                mem_we_o = 1'b1;
                s_d.wa   = s_q.wa + 1'b1;
                s_d.wcnt = s_q.wcnt + 1'b1;
            end else begin
                s_d.drop = 1'b1;
            end
        end
        len_d = s_d.wcnt;
        if (wr_abort_i) begin
            s_d.wa   = s_q.fs;
            s_d.wcnt = '0;
            s_d.drop = 1'b0;
        end else if (wr_commit_i) begin
            if (len_d == '0) begin
                s_d.drop = 1'b0;
            end else if (s_d.drop || table_full) begin
                s_d.wa   = s_q.fs;
                s_d.wcnt = '0;
                s_d.drop = 1'b0;
            end else begin
                desc_we_o = 1'b1;
                s_d.head  = s_q.head + 1'b1;
                s_d.fs    = s_d.wa;
                s_d.used  = s_q.used + len_d;
                s_d.wcnt  = '0;
            end
        end
        if (rel_fire_i) s_d.used = s_d.used - rel_len_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head_ptr_o   = s_q.head;
    assign mem_waddr_o  = s_q.wa;
    assign desc_waddr_o = s_q.head[FRAME_AW-1:0];
    assign desc_start_o = s_q.fs;
    assign desc_len_o   = len_d;
endmodule

// File: rtl/win_frame_buf.sv
module win_frame_buf #(
    parameter int unsigned       FRAME_AW = 6,
    parameter int unsigned       WORD_AW  = 8,
    parameter wfb_pkg::end_mode_e END_MODE = wfb_pkg::END_WITH_LAST,
    localparam int unsigned DW    = wfb_pkg::WORD_W,
    localparam int unsigned FP_W  = FRAME_AW + 1,
    localparam int unsigned LEN_W = WORD_AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_word_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          wr_commit_i,
    input  logic          wr_abort_i,
    input  logic          rd_release_i,
    input  logic          rd_win_reset_i,
    input  logic          rd_win_next_i,
    input  logic          rd_restart_i,
    input  logic          rd_word_i,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_last_o,
    output logic          frame_empty_o,
    output logic          win_empty_o,
    output logic          word_empty_o
);
    typedef struct packed {
        logic [FP_W-1:0]  tail;
        logic [FP_W-1:0]  win;
        logic [LEN_W-1:0] idx;
        logic             last;
    } rd_state_t;

    rd_state_t r_d, r_q;

    logic [FP_W-1:0]     head_ptr, tail_ptr, win_ptr;
    logic                mem_we, rd_en, rel_fire, desc_we;
    logic [WORD_AW-1:0]  mem_waddr, rd_addr, desc_start, win_start;
    logic [FRAME_AW-1:0] desc_waddr;
    logic [LEN_W-1:0]    desc_len, rel_len, win_len;

    assign tail_ptr = r_q.tail;
    assign win_ptr  = r_q.win;

    wfb_writer #(.FRAME_AW(FRAME_AW), .WORD_AW(WORD_AW)) u_writer (
        .clk(clk), .rst_n(rst_n),
        .wr_word_i(wr_word_i), .wr_commit_i(wr_commit_i), .wr_abort_i(wr_abort_i),
        .tail_ptr_i(tail_ptr), .rel_fire_i(rel_fire), .rel_len_i(rel_len),
        .head_ptr_o(head_ptr), .mem_we_o(mem_we), .mem_waddr_o(mem_waddr),
        .desc_we_o(desc_we), .desc_waddr_o(desc_waddr),
        .desc_start_o(desc_start), .desc_len_o(desc_len)
    );

    wfb_desc_table #(.FRAME_AW(FRAME_AW), .WORD_AW(WORD_AW)) u_desc (
        .clk(clk), .rst_n(rst_n),
        .we_i(desc_we), .waddr_i(desc_waddr), .wstart_i(desc_start), .wlen_i(desc_len),
        .rel_addr_i(tail_ptr[FRAME_AW-1:0]), .rel_len_o(rel_len),
        .win_addr_i(win_ptr[FRAME_AW-1:0]), .win_start_o(win_start), .win_len_o(win_len)
    );

    wfb_word_ram #(.ADDR_W(WORD_AW), .DATA_W(DW)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(wr_data_i),
        .re_i(rd_en), .raddr_i(rd_addr), .rdata_o(rd_data_o)
    );

    logic ctl_any, win_has_frame;
    assign ctl_any       = rd_release_i | rd_win_reset_i | rd_win_next_i | rd_restart_i;
    assign win_has_frame = r_q.win != head_ptr;
    assign rel_fire      = rd_release_i && (r_q.tail != head_ptr);
    assign rd_addr       = win_start + r_q.idx[WORD_AW-1:0];

    always_comb begin
        r_d   = r_q;
        rd_en = 1'b0;
        if (rel_fire) begin
            r_d.tail = r_q.tail + 1'b1;
            if (r_q.win == r_q.tail) begin
                r_d.win = r_d.tail;
                r_d.idx = '0;
            end
        end
        if (rd_win_reset_i) begin
            r_d.win = r_d.tail;
            r_d.idx = '0;
        end
        if (rd_win_next_i && (r_d.win != head_ptr)) begin
            r_d.win = r_d.win + 1'b1;
            r_d.idx = '0;
        end
        if (rd_restart_i) r_d.idx = '0;
        if (rd_word_i && !ctl_any && win_has_frame) begin
            if (r_q.idx < win_len) begin
                rd_en    = 1'b1;
                r_d.idx  = r_q.idx + 1'b1;
                r_d.last = (END_MODE == wfb_pkg::END_WITH_LAST) &&
                           ((r_q.idx + 1'b1) == win_len);
            end else if (END_MODE == wfb_pkg::END_AFTER_LAST) begin
                r_d.last = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_last_o     = r_q.last;
    assign frame_empty_o = head_ptr == r_q.tail;
    assign win_empty_o   = !win_has_frame;
    assign word_empty_o  = !win_has_frame || (r_q.idx == win_len);
endmodule

// File: rtl/win_frame_buf_chk.sv
module win_frame_buf_chk #(
    parameter int unsigned FRAME_AW = 6,
    localparam int unsigned FP_W   = FRAME_AW + 1,
    localparam int unsigned FRAMES = 1 << FRAME_AW
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_abort_i,
    input logic            rd_release_i,
    input logic            rd_win_reset_i,
    input logic            rd_win_next_i,
    input logic            rd_word_i,
    input logic            frame_empty_o,
    input logic            win_empty_o,
    input logic            rd_last_o,
    input logic [FP_W-1:0] head_ptr,
    input logic [FP_W-1:0] tail_ptr,
    input logic [FP_W-1:0] win_ptr
);
    a_r6_empty_release_holds: assert property (@(posedge clk) disable iff (!rst_n)
        rd_release_i && frame_empty_o |=> $stable(tail_ptr));

    a_r5_abort_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        wr_abort_i |=> head_ptr == $past(head_ptr));

    a_r8_next_ignored_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        rd_win_next_i && win_empty_o && !rd_win_reset_i |=> $stable(win_ptr));

    a_r11_frame_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (head_ptr - tail_ptr) <= FP_W'(FRAMES));

    a_r7_window_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (win_ptr - tail_ptr) <= (head_ptr - tail_ptr));

    a_r2_last_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_last_o) |-> $past(rd_word_i));
endmodule

bind win_frame_buf win_frame_buf_chk #(.FRAME_AW(FRAME_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_abort_i(wr_abort_i),
    .rd_release_i(rd_release_i), .rd_win_reset_i(rd_win_reset_i),
    .rd_win_next_i(rd_win_next_i), .rd_word_i(rd_word_i),
    .frame_empty_o(frame_empty_o), .win_empty_o(win_empty_o), .rd_last_o(rd_last_o),
    .head_ptr(head_ptr), .tail_ptr(tail_ptr), .win_ptr(win_ptr)
);

// File: tb/tb_win_frame_buf.sv
`timescale 1ns/1ps
module tb_win_frame_buf;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_word = 0, wr_commit = 0, wr_abort = 0;
    logic [31:0] wr_data = '0;
    logic rel = 0, wrst = 0, wnext = 0, rstrt = 0, rword = 0;
    logic [31:0] d_data, a_data;
    logic d_last, d_fe, d_we, d_ce, a_last, a_fe, a_we, a_ce;
    int n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    win_frame_buf #(.FRAME_AW(2), .WORD_AW(4), .END_MODE(wfb_pkg::END_WITH_LAST)) dut (
        .clk(clk), .rst_n(rst_n), .wr_word_i(wr_word), .wr_data_i(wr_data),
        .wr_commit_i(wr_commit), .wr_abort_i(wr_abort), .rd_release_i(rel),
        .rd_win_reset_i(wrst), .rd_win_next_i(wnext), .rd_restart_i(rstrt),
        .rd_word_i(rword), .rd_data_o(d_data), .rd_last_o(d_last),
        .frame_empty_o(d_fe), .win_empty_o(d_we), .word_empty_o(d_ce));

    win_frame_buf #(.FRAME_AW(2), .WORD_AW(4), .END_MODE(wfb_pkg::END_AFTER_LAST)) dut_alt (
        .clk(clk), .rst_n(rst_n), .wr_word_i(wr_word), .wr_data_i(wr_data),
        .wr_commit_i(wr_commit), .wr_abort_i(wr_abort), .rd_release_i(rel),
        .rd_win_reset_i(wrst), .rd_win_next_i(wnext), .rd_restart_i(rstrt),
        .rd_word_i(rword), .rd_data_o(a_data), .rd_last_o(a_last),
        .frame_empty_o(a_fe), .win_empty_o(a_we), .word_empty_o(a_ce));

    function automatic logic [31:0] dv(int tag, int i);
        return {8'h5A, 8'(tag), 16'(i)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic push(int tag, int i);
        wr_word = 1; wr_data = dv(tag, i); cyc(); wr_word = 0;
    endtask
    task automatic push_n(int tag, int n);
        for (int i = 0; i < n; i++) push(tag, i);
    endtask
    task automatic commit();  wr_commit = 1; cyc(); wr_commit = 0; endtask
    task automatic abort();   wr_abort = 1;  cyc(); wr_abort = 0;  endtask
    task automatic release_f(); rel = 1;     cyc(); rel = 0;       endtask
    task automatic wreset();  wrst = 1;      cyc(); wrst = 0;      endtask
    task automatic wstep();   wnext = 1;     cyc(); wnext = 0;     endtask
    task automatic restart(); rstrt = 1;     cyc(); rstrt = 0;     endtask

    task automatic rd_chk(string req, logic [31:0] exp, logic lastw);
        rword = 1; cyc(); rword = 0;
        chk({req, " data"}, d_data, exp);
        chk({req, " last"}, 32'(d_last), 32'(lastw));
        chk({req, " alt data"}, a_data, exp);
        chk({req, " alt last"}, 32'(a_last), 32'd0);
    endtask

    task automatic flags(string req, logic fe, logic we, logic ce);
        chk({req, " frame_empty"}, 32'(d_fe), 32'(fe));
        chk({req, " win_empty"},   32'(d_we), 32'(we));
        chk({req, " word_empty"},  32'(d_ce), 32'(ce));
        chk({req, " alt frame_empty"}, 32'(a_fe), 32'(fe));
    endtask

    initial begin
        #(200000 * 5);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        flags("R10 reset", 1, 1, 1);
        chk("R10 reset last", 32'(d_last), 0);

        // R1 R2 R3 R9 sweep over frame lengths; store wraps
        for (int len = 1; len <= 6; len++) begin
            push_n(len, len);
            commit();
            chk("R4 commit visible", 32'(d_fe), 0);
            wreset();
            flags("R10 window set", 0, 0, 0);
            for (int i = 0; i < len; i++) rd_chk("R1 R2 word", dv(len, i), i == len - 1);
            chk("R10 all read", 32'(d_ce), 1);
            chk("R3 alt all read", 32'(a_ce), 1);
            rword = 1; cyc(); rword = 0;
            chk("R2 extra read holds last", 32'(d_last), 1);
            chk("R2 extra read holds data", d_data, dv(len, len - 1));
            chk("R3 end marker after last", 32'(a_last), 1);
            restart();
            chk("R9 restart word_empty", 32'(d_ce), 0);
            rd_chk("R9 reread first", dv(len, 0), len == 1);
            release_f();
            flags("R6 released", 1, 1, 1);
        end

        // R7 R8 replay across three frames
        push_n(20, 2); commit();
        push_n(21, 3); commit();
        push_n(22, 4); commit();
        wreset();
        rd_chk("R7 window at oldest", dv(20, 0), 0);
        wstep();
        rd_chk("R8 next frame", dv(21, 0), 0);
        rd_chk("R8 next frame w1", dv(21, 1), 0);
        wstep();
        rd_chk("R8 third frame", dv(22, 0), 0);
        wstep();
        flags("R8 window past newest", 0, 1, 1);
        wstep();
        chk("R8 step ignored", 32'(d_we), 1);
        wreset();
        rd_chk("R7 reset after replay", dv(20, 0), 0);
        release_f();
        rd_chk("R6 window follows release", dv(21, 0), 0);
        wreset();
        rd_chk("R7 reset to new oldest", dv(21, 0), 0);
        release_f(); release_f();
        flags("R6 all freed", 1, 1, 1);

        // R4 zero-word commit, R6 release when empty
        commit();
        chk("R4 zero commit no frame", 32'(d_fe), 1);
        release_f();
        chk("R6 empty release", 32'(d_fe), 1);
        push_n(30, 1); commit(); wreset();
        rd_chk("R6 after empty release", dv(30, 0), 1);
        release_f();

        // R5 abort
        push_n(40, 3); abort();
        chk("R5 aborted not visible", 32'(d_fe), 1);
        push_n(41, 2); commit(); wreset();
        rd_chk("R5 next frame w0", dv(41, 0), 0);
        rd_chk("R5 next frame w1", dv(41, 1), 1);
        chk("R5 length excludes aborted", 32'(d_ce), 1);
        release_f();

        // R11 frame table capacity
        for (int k = 0; k < 5; k++) begin push_n(50 + k, 1); commit(); end
        for (int k = 0; k < 4; k++) begin
            wreset();
            rd_chk("R11 stored frame", dv(50 + k, 0), 1);
            release_f();
        end
        chk("R11 fifth commit dropped", 32'(d_fe), 1);

        // R12 word-store overflow and reuse
        push_n(60, 17); commit();
        chk("R12 oversize dropped", 32'(d_fe), 1);
        push_n(61, 16); commit();
        chk("R12 full-size accepted", 32'(d_fe), 0);
        wreset();
        for (int i = 0; i < 16; i++) rd_chk("R12 full frame", dv(61, i), i == 15);
        release_f();
        flags("R12 drained", 1, 1, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule